// File: doc/BRIEF.md
# Channel-Triggered Zero Suppression Window

This block decides, for a bank of ADC channels, which baseline-subtracted samples are worth keeping. Every sample period each channel's 12-bit two's-complement sample is reduced to a magnitude and compared with a programmable threshold. A channel whose magnitude exceeds the threshold triggers capture on itself and on the channels on either side of it, so that small induced signals shared with adjacent wires are kept as well.

The sample stream is delayed by a programmable pre-trigger depth, so the samples just before a crossing can still be written. A per-channel window counter keeps the write strobe high for a programmable number of samples after the last trigger. The two outer channels exchange trigger lines with the neighbouring bank. A host trigger input forces capture on all channels at once. The outputs are a delayed copy of every sample and a per-channel write strobe that a downstream buffer uses to store the samples.

Top module: `zs_window_top`

## Requirements
- R1: Reset (synchronous, active low) clears `out_valid_o`, `wr_en_o`, `data_o`, every delay stage and every window counter. An open window does not survive a reset.
- R2: A channel hits when the magnitude of its sample, read as 12-bit two's complement, is strictly greater than `threshold_i`. This holds for both polarities. A magnitude equal to the threshold does not hit, and -2048 has magnitude 2048.
- R3: A hit on channel k triggers channels k-1, k and k+1 and no other channel.
- R4: `data_o` lane k carries the sample of channel k taken `pre_depth_i` sample periods earlier, with 0 meaning the current sample. A trigger therefore also writes the `pre_depth_i` samples that came before it.
- R5: After the last trigger on a channel, its write strobe stays high for `post_depth_i` further sample periods. A single trigger yields exactly `pre_depth_i + post_depth_i + 1` written samples.
- R6: A trigger that arrives while a window is still open extends it. The written samples stay contiguous, and each input sample is written at most once.
- R7: `nbr_lo_i` triggers channel 0 and `nbr_hi_i` triggers channel 7, each standing in for the missing neighbour. `nbr_lo_o` is the combinational hit of channel 0 and `nbr_hi_o` is the combinational hit of channel 7.
- R8: `ext_trig_i` triggers every channel during the sample period in which it is high.
- R9: `out_valid_o` is high for exactly the one clock after each clock in which `sample_valid_i` is high. `wr_en_o` is zero whenever `out_valid_o` is low.
- R10: While `sample_valid_i` is low, no state advances: `data_o` holds, and the windows count only sample periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid_i | input | 1 | One-clock strobe per sample period |
| samples_i | input | 96 | Eight 12-bit signed samples, channel k at bits [12k+11:12k] |
| threshold_i | input | 12 | Magnitude threshold |
| pre_depth_i | input | 4 | Samples kept ahead of a trigger (0 to 15) |
| post_depth_i | input | 4 | Samples kept after the last trigger (0 to 15) |
| ext_trig_i | input | 1 | Host trigger forcing all channels |
| nbr_lo_i | input | 1 | Hit from the bank below channel 0 |
| nbr_hi_i | input | 1 | Hit from the bank above channel 7 |
| nbr_lo_o | output | 1 | Hit of channel 0, to the bank below |
| nbr_hi_o | output | 1 | Hit of channel 7, to the bank above |
| out_valid_o | output | 1 | Output sample period strobe |
| wr_en_o | output | 8 | Per-channel write strobe, qualified by out_valid_o |
| data_o | output | 96 | Delayed samples, same lane layout as samples_i |

## Verification
A corrupted delay stage shows up as a wrong value on one `data_o` lane. This happens exactly `pre_depth_i` sample periods after the bad sample entered, and each lane is compared against the driven history. A window counter that is wrong in state shows as a write-strobe run of the wrong length, or as a gap inside an extended run. It is visible in the first output period past the expected end of the window. Mis-wired neighbour or edge trigger logic changes the strobe mask in the very next output period.

// File: rtl/zs_pkg.sv
// Package with the default geometry of the zero-suppression window.
// Assumes all consumers take their parameter defaults from here.
package zs_pkg;
    localparam int unsigned ZS_NCH      = 8;   // channels per bank
    localparam int unsigned ZS_SW       = 12;  // sample width
    localparam int unsigned ZS_PRE_MAX  = 15;  // deepest pre-trigger delay
    localparam int unsigned ZS_POST_MAX = 15;  // longest post-trigger extension

    // Bits needed to hold values 0..n.
    function automatic int unsigned zs_bits(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/zs_mag_cmp.sv
// Magnitude comparator: flags a two's-complement sample whose absolute
// value is strictly above an unsigned threshold. Purely combinational.
// Assumes the most negative code maps to magnitude 2^(SW-1).
module zs_mag_cmp #(
    parameter int unsigned SW = 12
) (
    input  logic [SW-1:0] smp_i,
    input  logic [SW-1:0] thr_i,
    output logic          hit_o
);
    logic [SW-1:0] mag;

    // Absolute value, then strict compare.
    always_comb begin
        mag   = smp_i[SW-1] ? (~smp_i + 1'b1) : smp_i;
        hit_o = (mag > thr_i);
    end
endmodule

// File: rtl/zs_delay_line.sv
// Per-channel sample delay with a selectable tap. Shifts once per sample
// period. Tap 0 is the live input; tap n is the sample n periods back.
// Assumes sel_i beyond PRE_MAX is clamped to the deepest stage.
module zs_delay_line #(
    parameter int unsigned SW      = 12,
    parameter int unsigned PRE_MAX = 15,
    parameter int unsigned PW      = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic [SW-1:0] din_i,
    input  logic [PW-1:0] sel_i,
    output logic [SW-1:0] dout_o
);
    logic [SW-1:0] stage [PRE_MAX];
    logic [PW-1:0] sel_c;

    // Shift the sample history on every sample strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < int'(PRE_MAX); k++) stage[k] <= '0;
        end else if (adv_i) begin
            stage[0] <= din_i;
            for (int k = 1; k < int'(PRE_MAX); k++) stage[k] <= stage[k-1];
        end
    end

    // Pick the tap that matches the requested pre-trigger depth.
    always_comb begin
        sel_c  = (sel_i > PW'(PRE_MAX)) ? PW'(PRE_MAX) : sel_i;
        dout_o = (sel_c == '0) ? din_i : stage[sel_c - 1'b1];
    end
endmodule

// File: rtl/zs_gate_ctr.sv
// Per-channel write window. A trigger reloads the remaining length.
// The keep flag is high during a trigger and while the count is nonzero.
// Assumes the reload equals pre depth plus post depth, which keeps a
// delayed sample whenever a trigger fell within the span it must cover.
module zs_gate_ctr #(
    parameter int unsigned CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv_i,
    input  logic          trig_i,
    input  logic [CW-1:0] reload_i,
    output logic          keep_o
);
    logic [CW-1:0] remain;

    // Reload on trigger, otherwise count down to zero per sample period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain <= '0;
        end else if (adv_i) begin
            if (trig_i)               remain <= reload_i;
            else if (remain != '0)    remain <= remain - 1'b1;
        end
    end

    // Window is open on the trigger period and while count remains.
    always_comb keep_o = trig_i || (remain != '0);
endmodule

// File: rtl/zs_window_top.sv
// Channel-triggered zero-suppression window for one bank of channels.
// Each channel's hit triggers itself and both neighbours. The outer
// neighbours come from the adjacent bank, and a host trigger forces all.
// Outputs are registered once per sample strobe: a delayed sample per lane
// and a write strobe per lane, qualified by out_valid_o.
// Assumes the depth settings are held stable while windows are open.
module zs_window_top
    import zs_pkg::*;
#(
    parameter int unsigned NCH      = ZS_NCH,
    parameter int unsigned SW       = ZS_SW,
    parameter int unsigned PRE_MAX  = ZS_PRE_MAX,
    parameter int unsigned POST_MAX = ZS_POST_MAX,
    parameter int unsigned PW       = zs_bits(PRE_MAX),
    parameter int unsigned QW       = zs_bits(POST_MAX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid_i,
    input  logic [NCH*SW-1:0] samples_i,
    input  logic [SW-1:0]     threshold_i,
    input  logic [PW-1:0]     pre_depth_i,
    input  logic [QW-1:0]     post_depth_i,
    input  logic              ext_trig_i,
    input  logic              nbr_lo_i,
    input  logic              nbr_hi_i,
    output logic              nbr_lo_o,
    output logic              nbr_hi_o,
    output logic              out_valid_o,
    output logic [NCH-1:0]    wr_en_o,
    output logic [NCH*SW-1:0] data_o
);
    localparam int unsigned CW = zs_bits(PRE_MAX + POST_MAX);

    logic [NCH-1:0]    hit;
    logic [NCH+1:0]    hit_ext;
    logic [NCH-1:0]    trig;
    logic [NCH-1:0]    keep;
    logic [NCH*SW-1:0] tap;
    logic [CW-1:0]     reload;

    // Window length shared by all channels.
    always_comb reload = CW'(pre_depth_i) + CW'(post_depth_i);

    // Hit vector widened with the neighbour-bank lines at both ends.
    always_comb hit_ext = {nbr_hi_i, hit, nbr_lo_i};

    // Edge hits go out to the adjacent banks.
    always_comb begin
        nbr_lo_o = hit[0];
        nbr_hi_o = hit[NCH-1];
    end

    for (genvar k = 0; k < int'(NCH); k++) begin : g_ch
        zs_mag_cmp #(.SW(SW)) u_cmp (
            .smp_i (samples_i[k*SW +: SW]),
            .thr_i (threshold_i),
            .hit_o (hit[k])
        );

        // Trigger from own hit, either neighbour, or the host.
        always_comb trig[k] = hit_ext[k] | hit_ext[k+1] | hit_ext[k+2] | ext_trig_i;

        zs_delay_line #(.SW(SW), .PRE_MAX(PRE_MAX), .PW(PW)) u_dly (
            .clk    (clk),
            .rst_n  (rst_n),
            .adv_i  (sample_valid_i),
            .din_i  (samples_i[k*SW +: SW]),
            .sel_i  (pre_depth_i),
            .dout_o (tap[k*SW +: SW])
        );

        zs_gate_ctr #(.CW(CW)) u_gate (
            .clk      (clk),
            .rst_n    (rst_n),
            .adv_i    (sample_valid_i),
            .trig_i   (trig[k]),
            .reload_i (reload),
            .keep_o   (keep[k])
        );
    end

    // Output register: one update per sample strobe, strobes cleared between.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid_o <= 1'b0;
            wr_en_o     <= '0;
            data_o      <= '0;
        end else begin
            out_valid_o <= sample_valid_i;
            wr_en_o     <= sample_valid_i ? keep : '0;
            if (sample_valid_i) data_o <= tap;
        end
    end
endmodule

// File: rtl/zs_window_checker.sv
// Port-level properties of the zero-suppression window, bound to the top.
// Assumes the default bank of eight channels for the edge checks.
module zs_window_checker #(
    parameter int unsigned NCH = 8,
    parameter int unsigned SW  = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sample_valid_i,
    input logic              ext_trig_i,
    input logic              nbr_lo_i,
    input logic              nbr_hi_i,
    input logic              nbr_lo_o,
    input logic              nbr_hi_o,
    input logic              out_valid_o,
    input logic [NCH-1:0]    wr_en_o,
    input logic [NCH*SW-1:0] data_o
);
    // R9: every sample strobe produces an output period next clock.
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid_i |=> out_valid_o);

    // R9: no output period without a strobe.
    p_valid_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid_i |=> !out_valid_o);

    // R9: write strobes only inside output periods.
    p_wr_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> (wr_en_o == '0));

    // R10: samples hold between strobes.
    p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_valid_i |=> $stable(data_o));

    // R8: host trigger opens every channel.
    p_ext_all_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_i && ext_trig_i) |=> (&wr_en_o));

    // R7: lower neighbour line or channel 0 hit opens channel 0.
    p_lo_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_i && (nbr_lo_i || nbr_lo_o)) |=> wr_en_o[0]);

    // R7: upper neighbour line or last channel hit opens the last channel.
    p_hi_edge_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_i && (nbr_hi_i || nbr_hi_o)) |=> wr_en_o[NCH-1]);

    // R3: an edge hit also opens the inner neighbour.
    p_lo_nbr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid_i && nbr_lo_o) |=> wr_en_o[1]);
endmodule

bind zs_window_top zs_window_checker #(.NCH(NCH), .SW(SW)) u_zs_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .sample_valid_i (sample_valid_i),
    .ext_trig_i     (ext_trig_i),
    .nbr_lo_i       (nbr_lo_i),
    .nbr_hi_i       (nbr_hi_i),
    .nbr_lo_o       (nbr_lo_o),
    .nbr_hi_o       (nbr_hi_o),
    .out_valid_o    (out_valid_o),
    .wr_en_o        (wr_en_o),
    .data_o         (data_o)
);

// File: tb/zs_window_top_tb_top.sv
// Self-checking bench for the zero-suppression window.
module zs_window_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid_i = 1'b0;
    logic [95:0] samples_i = '0;
    logic [11:0] threshold_i = 12'd100;
    logic [3:0]  pre_depth_i = 4'd1;
    logic [3:0]  post_depth_i = 4'd1;
    logic        ext_trig_i = 1'b0;
    logic        nbr_lo_i = 1'b0;
    logic        nbr_hi_i = 1'b0;
    logic        nbr_lo_o, nbr_hi_o, out_valid_o;
    logic [7:0]  wr_en_o;
    logic [95:0] data_o;

    always #10 clk = ~clk;

    zs_window_top dut_i (
        .clk(clk), .rst_n(rst_n), .sample_valid_i(sample_valid_i),
        .samples_i(samples_i), .threshold_i(threshold_i),
        .pre_depth_i(pre_depth_i), .post_depth_i(post_depth_i),
        .ext_trig_i(ext_trig_i), .nbr_lo_i(nbr_lo_i), .nbr_hi_i(nbr_hi_i),
        .nbr_lo_o(nbr_lo_o), .nbr_hi_o(nbr_hi_o), .out_valid_o(out_valid_o),
        .wr_en_o(wr_en_o), .data_o(data_o)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int stepn   = 0;
    logic [11:0] hist [0:511][0:7];
    logic [7:0]  got_wr;
    logic        got_ov, got_lo, got_hi, idle_ok;
    logic [95:0] got_data;

    // Stimulus {hit mask[19:12], negative[11], ext[10], nbr_lo[9], nbr_hi[8], expected wr_en[7:0]}
    // at threshold 100, pre depth 1, post depth 1; hit channels carry +/-500.
    localparam logic [19:0] VEC [0:16] = '{
        20'h00000, 20'h0801C, 20'h0001C, 20'h0001C, 20'h00000,
        20'h01803, 20'h00183, 20'h00083, 20'h00080, 20'h004FF,
        20'h002FF, 20'h400FF, 20'h000E1, 20'h000E0, 20'h00000,
        20'h828C7, 20'h000C7
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One sample period: drive at a falling edge, read outputs one clock later.
    task automatic do_step(input logic [7:0] hm, input logic [11:0] hv,
                           input logic ext, input logic nlo, input logic nhi);
        @(negedge clk);
        for (int c = 0; c < 8; c++) begin
            logic [11:0] v;
            v = hm[c] ? hv : 12'((stepn * 8 + c) % 90);
            samples_i[c*12 +: 12] = v;
            hist[stepn][c] = v;
        end
        sample_valid_i = 1'b1;
        ext_trig_i = ext; nbr_lo_i = nlo; nbr_hi_i = nhi;
        #1 got_lo = nbr_lo_o; got_hi = nbr_hi_o;
        @(negedge clk);
        sample_valid_i = 1'b0; ext_trig_i = 1'b0; nbr_lo_i = 1'b0; nbr_hi_i = 1'b0;
        #1 got_wr = wr_en_o; got_ov = out_valid_o; got_data = data_o;
        @(negedge clk);
        #1 idle_ok = (wr_en_o == 8'h00) && !out_valid_o;
        stepn++;
    endtask

    task automatic idle_step();
        do_step(8'h00, 12'd0, 1'b0, 1'b0, 1'b0);
    endtask

    function automatic logic [11:0] exp_lane(input int s, input int p, input int c);
        return (s - p >= 0) ? hist[s-p][c] : 12'd0;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int k;
        logic [95:0] held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        check("R1 reset out_valid", 32'(out_valid_o), 32'd0);
        check("R1 reset wr_en", 32'(wr_en_o), 32'd0);
        check("R1 reset data", 32'(data_o[31:0] | data_o[63:32] | data_o[95:64]), 32'd0);

        // Vector table: R3 neighbour gating, R7 edges, R8 host, R4 delay 1, R9 timing
        for (int i = 0; i < 17; i++) begin
            logic [19:0] v;
            v = VEC[i];
            do_step(v[19:12], v[11] ? 12'hE0C : 12'd500, v[10], v[9], v[8]);
            check($sformatf("R3 vector %0d wr_en", i), 32'(got_wr), 32'(v[7:0]));
            check($sformatf("R9 vector %0d out_valid", i), 32'(got_ov), 32'd1);
            check($sformatf("R9 vector %0d idle", i), 32'(idle_ok), 32'd1);
            check($sformatf("R7 vector %0d lo out", i), 32'(got_lo), 32'(v[12]));
            check($sformatf("R7 vector %0d hi out", i), 32'(got_hi), 32'(v[19]));
            for (int c = 0; c < 8; c++)
                check($sformatf("R4 vector %0d lane %0d", i, c),
                      32'(got_data[c*12 +: 12]), 32'(exp_lane(i, 1, c)));
        end

        // R2: threshold edges, both polarities, with no extension
        pre_depth_i = 4'd0; post_depth_i = 4'd0;
        repeat (3) idle_step();
        do_step(8'h04, 12'd100, 0, 0, 0);
        check("R2 equal positive", 32'(got_wr), 32'h00);
        check("R4 depth zero live lane", 32'(got_data[24 +: 12]), 32'd100);
        do_step(8'h04, 12'hF9C, 0, 0, 0);
        check("R2 equal negative", 32'(got_wr), 32'h00);
        do_step(8'h04, 12'd101, 0, 0, 0);
        check("R2 above positive", 32'(got_wr), 32'h0E);
        do_step(8'h04, 12'hF9B, 0, 0, 0);
        check("R2 above negative", 32'(got_wr), 32'h0E);
        threshold_i = 12'd2047;
        do_step(8'h04, 12'd2047, 0, 0, 0);
        check("R2 full scale equal", 32'(got_wr), 32'h00);
        do_step(8'h04, 12'h800, 0, 0, 0);
        check("R2 most negative", 32'(got_wr), 32'h0E);
        threshold_i = 12'd100;

        // R4 and R5: deepest pre and post depths, single trigger on channel 4
        pre_depth_i = 4'd15; post_depth_i = 4'd15;
        idle_step();
        k = stepn;
        do_step(8'h10, 12'd700, 0, 0, 0);
        check("R5 max window start", 32'(got_wr), 32'h38);
        check("R4 max depth first sample", 32'(got_data[48 +: 12]), 32'(exp_lane(k, 15, 4)));
        for (int j = 1; j <= 31; j++) begin
            idle_step();
            check($sformatf("R5 max window +%0d", j), 32'(got_wr), (j <= 30) ? 32'h38 : 32'h00);
        end

        // R6: retrigger inside the window keeps one contiguous run
        pre_depth_i = 4'd2; post_depth_i = 4'd2;
        idle_step();
        k = stepn;
        for (int j = 0; j < 10; j++) begin
            if (j == 0 || j == 3) do_step(8'h10, 12'd300, 0, 0, 0);
            else idle_step();
            check($sformatf("R6 run +%0d", j), 32'(got_wr), (j <= 7) ? 32'h38 : 32'h00);
            if (j <= 7)
                check($sformatf("R6 lane data +%0d", j), 32'(got_data[48 +: 12]),
                      32'(hist[k + j - 2][4]));
        end

        // R10: a long pause without strobes does not consume the window
        pre_depth_i = 4'd0; post_depth_i = 4'd3;
        idle_step();
        do_step(8'h02, 12'd400, 0, 0, 0);
        check("R10 trigger", 32'(got_wr), 32'h07);
        held = data_o;
        repeat (40) @(negedge clk);
        #1;
        check("R10 data held", 32'(held == data_o), 32'd1);
        check("R10 no strobe in pause", 32'(wr_en_o), 32'h00);
        for (int j = 1; j <= 4; j++) begin
            idle_step();
            check($sformatf("R10 window after pause +%0d", j), 32'(got_wr), (j <= 3) ? 32'h07 : 32'h00);
        end

        // R1: reset closes an open window
        post_depth_i = 4'd15;
        do_step(8'h40, 12'd900, 0, 0, 0);
        check("R1 pre-reset window", 32'(got_wr), 32'hE0);
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 mid reset data", 32'(data_o == '0), 32'd1);
        check("R1 mid reset valid", 32'(out_valid_o), 32'd0);
        idle_step();
        check("R1 window cleared", 32'(got_wr), 32'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule